// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Unit

This unit performs the interrupt-check step that a processor runs after each instruction's execute step. It holds six pending event flags: arithmetic overflow, memory-protection violation, privileged instruction in user mode, timer expiry, I/O completion and supervisor call. When the sequencer asks for a check, the unit picks the most urgent pending flag and redirects the program counter to that cause's entry in a six-entry handler vector table. It also switches the processor to supervisor mode and clears the flag it served.

The three fatal causes (overflow, protection, privilege) jump straight to their handler and save nothing. The three resumable causes (timer, I/O, supervisor call) first write the current program counter to a memory stack at the stack pointer and advance the pointer by one. The handler load follows one cycle later. A built-in down-counting watchdog raises the timer flag. A supervisor call also latches the service index taken from the instruction's address field, for the handler's later table lookup.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, `mem_we`, `pc_we` and `done` are 0, `sup_mode` is 0 (user), no flag is pending and `sp_out` equals `SP_BASE`.
- R2: A check (`check_req` high at an edge while idle) with no flag pending raises `done` for one cycle after that edge. It leaves `pc_we` and `mem_we` low and keeps `sp_out` and `sup_mode` unchanged.
- R3: The fatal causes use fixed vector indices: overflow 0, protection 1, privilege 2. Serving one raises `pc_we` and `done` one cycle after the check edge, with `pc_next` equal to that vector entry and `sup_mode` 1. No memory write occurs and `sp_out` does not change.
- R4: The resumable causes use fixed vector indices: timer 3, I/O 4, supervisor call 5. Serving one raises `mem_we` one cycle after the check edge, with `mem_addr` equal to the old `sp_out` and `mem_wdata` equal to `pc_in`, and `sp_out` becomes old+1. In the next cycle `pc_we` and `done` go high, with `pc_next` equal to the vector entry and `sup_mode` 1.
- R5: Each check serves exactly one flag. When several are pending, the order is overflow, protection, privilege, timer, I/O, supervisor call.
- R6: The served flag is cleared by its check. Other pending flags stay pending for later checks.
- R7: `tmr_load` loads `tmr_value` into the watchdog. The watchdog counts down by one each cycle, and the timer flag is pending from the edge at which it reaches zero. It then stays at zero and raises no further flag until reloaded. Loading zero stops it without raising the flag.
- R8: `ev_svc` latches `svc_index` into `svc_b`.
- R9: `user_ret` returns `sup_mode` to 0. A `check_req` seen while a push is in progress is ignored.
- Vector entry k occupies `vec_table[k*AW +: AW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| check_req | input | 1 | Run an interrupt check |
| ev_ov | input | 1 | Set overflow flag |
| ev_mp | input | 1 | Set memory-protection flag |
| ev_pi | input | 1 | Set privileged-instruction flag |
| ev_io | input | 1 | Set I/O-completion flag |
| ev_svc | input | 1 | Set supervisor-call flag, latch index |
| svc_index | input | IW | Service index from instruction address field |
| tmr_load | input | 1 | Load watchdog |
| tmr_value | input | TW | Watchdog load value |
| user_ret | input | 1 | Return to user mode |
| pc_in | input | AW | Current program counter |
| vec_table | input | 6*AW | Handler vector table |
| mem_we | output | 1 | Stack write strobe |
| mem_addr | output | AW | Stack write address |
| mem_wdata | output | AW | Saved return PC |
| pc_we | output | 1 | Load PC strobe |
| pc_next | output | AW | Handler address |
| sup_mode | output | 1 | 1 = supervisor mode |
| done | output | 1 | Check finished, return to fetch |
| sp_out | output | AW | Stack pointer |
| svc_b | output | IW | Latched service index |

## Verification
The bench builds the unit with a 12-bit address width, an 8-bit watchdog and a 4-bit service index. The short watchdog lets a full expiry and the stop-at-zero behaviour fit within a few cycles. The stack base of 0x0F0 with distinct vector entries makes every push address and handler target distinguishable in the scoreboard. The same short counter lets a check land exactly one cycle before and one cycle after expiry, to pin the timing of the timer flag.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int AW = 16,
  parameter int TW = 16,
  parameter int IW = 8,
  parameter int unsigned SP_BASE = 'h0F00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            check_req,
  input  logic            ev_ov,
  input  logic            ev_mp,
  input  logic            ev_pi,
  input  logic            ev_io,
  input  logic            ev_svc,
  input  logic [IW-1:0]   svc_index,
  input  logic            tmr_load,
  input  logic [TW-1:0]   tmr_value,
  input  logic            user_ret,
  input  logic [AW-1:0]   pc_in,
  input  logic [6*AW-1:0] vec_table,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [AW-1:0]   mem_wdata,
  output logic            pc_we,
  output logic [AW-1:0]   pc_next,
  output logic            sup_mode,
  output logic            done,
  output logic [AW-1:0]   sp_out,
  output logic [IW-1:0]   svc_b
);

  localparam int NCAUSE = 6;
  localparam int FIRST_RESUME = 3;

  logic [NCAUSE-1:0] pend, set_v, clr_v, win;
  logic [2:0]        win_idx, held_idx;
  logic [TW-1:0]     tcnt;
  logic              busy, ti_set, take;

  assign ti_set = (tcnt == TW'(1)) && !tmr_load;
  assign set_v  = {ev_svc, ev_io, ti_set, ev_pi, ev_mp, ev_ov};
  assign take   = check_req && !busy;

  always_comb begin
    win_idx = 3'd0;
    for (int k = NCAUSE-1; k >= 0; k--)
      if (pend[k]) win_idx = 3'(k);
  end

  assign win   = (pend != '0) ? (NCAUSE'(1) << win_idx) : '0;
  assign clr_v = take ? win : '0;

  function automatic logic [AW-1:0] vec_of(input logic [2:0] i);
    return vec_table[i*AW +: AW];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      tcnt      <= '0;
      svc_b     <= '0;
      busy      <= 1'b0;
      held_idx  <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      pc_we     <= 1'b0;
      pc_next   <= '0;
      sup_mode  <= 1'b0;
      done      <= 1'b0;
      sp_out    <= AW'(SP_BASE);
    end else begin
      pend   <= (pend & ~clr_v) | set_v;
      mem_we <= 1'b0;
      pc_we  <= 1'b0;
      done   <= 1'b0;

      if (tmr_load)            tcnt <= tmr_value;
      else if (tcnt != '0)     tcnt <= tcnt - TW'(1);

      if (ev_svc) svc_b <= svc_index;
      if (user_ret) sup_mode <= 1'b0;

      if (busy) begin
        busy     <= 1'b0;
        pc_we    <= 1'b1;
        pc_next  <= vec_of(held_idx);
        sup_mode <= 1'b1;
        done     <= 1'b1;
      end else if (check_req) begin
        if (pend == '0) begin
          done <= 1'b1;
        end else if (int'(win_idx) < FIRST_RESUME) begin
          pc_we    <= 1'b1;
          pc_next  <= vec_of(win_idx);
          sup_mode <= 1'b1;
          done     <= 1'b1;
        end else begin
          mem_we    <= 1'b1;
          mem_addr  <= sp_out;
          mem_wdata <= pc_in;
          sp_out    <= sp_out + AW'(1);
          held_idx  <= win_idx;
          busy      <= 1'b1;
        end
      end
    end
  end

endmodule

module irq_dispatch_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          pc_we,
  input logic          done,
  input logic          sup_mode,
  input logic [AW-1:0] sp_out
);

  p_push_then_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (pc_we && done));

  p_sp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (sp_out == mem_addr + AW'(1)));

  p_no_push_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && pc_we));

  p_load_is_super_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> (sup_mode && done));

  p_sp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |-> $stable(sp_out));

  p_push_not_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !done);

endmodule

bind irq_dispatch irq_dispatch_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .pc_we(pc_we), .done(done), .sup_mode(sup_mode), .sp_out(sp_out)
);

// File: tb/test_irq_dispatch.sv
module test_irq_dispatch;
  localparam int AW = 12;
  localparam int TW = 8;
  localparam int IW = 4;
  localparam int unsigned SPB = 'h0F0;

  logic clk = 0, rst_n = 0;
  logic check_req = 0, ev_ov = 0, ev_mp = 0, ev_pi = 0, ev_io = 0, ev_svc = 0;
  logic [IW-1:0] svc_index = '0;
  logic tmr_load = 0;
  logic [TW-1:0] tmr_value = '0;
  logic user_ret = 0;
  logic [AW-1:0] pc_in = '0;
  logic [6*AW-1:0] vec_table;
  logic mem_we, pc_we, sup_mode, done;
  logic [AW-1:0] mem_addr, mem_wdata, pc_next, sp_out;
  logic [IW-1:0] svc_b;

  always #2.5 clk = ~clk;

  irq_dispatch #(.AW(AW), .TW(TW), .IW(IW), .SP_BASE(SPB)) i_irq_dispatch (
    .clk(clk), .rst_n(rst_n), .check_req(check_req), .ev_ov(ev_ov), .ev_mp(ev_mp),
    .ev_pi(ev_pi), .ev_io(ev_io), .ev_svc(ev_svc), .svc_index(svc_index),
    .tmr_load(tmr_load), .tmr_value(tmr_value), .user_ret(user_ret), .pc_in(pc_in),
    .vec_table(vec_table), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc_we(pc_we), .pc_next(pc_next), .sup_mode(sup_mode), .done(done),
    .sp_out(sp_out), .svc_b(svc_b));

  typedef struct packed {
    logic [1:0]    kind;  // 0 none, 1 push, 2 load
    logic [AW-1:0] a;
    logic [AW-1:0] d;
  } exp_t;

  exp_t q[$];
  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [AW-1:0] sp_m;
  string cur_req = "R2";

  function automatic logic [AW-1:0] vec(int k);
    return AW'('h100 + k * 'h11);
  endfunction

  initial for (int k = 0; k < 6; k++) vec_table[k*AW +: AW] = vec(k);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_we || pc_we || done) begin
      exp_t e;
      int k;
      k = mem_we ? 1 : (pc_we ? 2 : 0);
      if (q.size() == 0) chk(0, cur_req, k, 3);
      else begin
        e = q.pop_front();
        chk(int'(e.kind) == k, cur_req, k, int'(e.kind));
        if (k == 1) begin
          chk(mem_addr == e.a, {cur_req, " push addr"}, int'(mem_addr), int'(e.a));
          chk(mem_wdata == e.d, {cur_req, " push data"}, int'(mem_wdata), int'(e.d));
        end else if (k == 2) begin
          chk(pc_next == e.a, {cur_req, " vector"}, int'(pc_next), int'(e.a));
          chk(sup_mode, {cur_req, " mode"}, int'(sup_mode), 1);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      finish_run();
    end
  end

  task automatic exp_none();  q.push_back('{2'd0, '0, '0}); endtask
  task automatic exp_fatal(int k); q.push_back('{2'd2, vec(k), '0}); endtask
  task automatic exp_resume(int k);
    q.push_back('{2'd1, sp_m, pc_in});
    q.push_back('{2'd2, vec(k), '0});
    sp_m = sp_m + AW'(1);
  endtask

  task automatic do_check(int hold);
    @(negedge clk) check_req = 1;
    repeat (hold) @(negedge clk);
    check_req = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(bit o, bit m, bit p, bit io, bit s);
    @(negedge clk) begin ev_ov = o; ev_mp = m; ev_pi = p; ev_io = io; ev_svc = s; end
    @(negedge clk) begin ev_ov = 0; ev_mp = 0; ev_pi = 0; ev_io = 0; ev_svc = 0; end
  endtask

  task automatic ret_user();
    @(negedge clk) user_ret = 1;
    @(negedge clk) user_ret = 0;
  endtask

  initial begin
    sp_m = AW'(SPB);
    pc_in = 'h234;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!mem_we && !pc_we && !done, "R1 strobes", {mem_we, pc_we, done}, 0);
    chk(!sup_mode, "R1 mode", sup_mode, 0);
    chk(sp_out == AW'(SPB), "R1 sp", sp_out, SPB);
    rst_n = 1;
    @(negedge clk);
    chk(sp_out == AW'(SPB), "R1 sp after", sp_out, SPB);

    // R2 empty check, nothing pending after reset
    cur_req = "R2"; exp_none(); do_check(1);
    chk(sp_out == sp_m, "R2 sp", sp_out, sp_m);
    chk(!sup_mode, "R2 mode", sup_mode, 0);

    // R3 each fatal cause alone
    cur_req = "R3"; pulse(1,0,0,0,0); exp_fatal(0); do_check(1);
    chk(sp_out == sp_m, "R3 sp unchanged", sp_out, sp_m);
    ret_user();
    chk(!sup_mode, "R9 user_ret", sup_mode, 0);
    pulse(0,1,0,0,0); exp_fatal(1); do_check(1);
    ret_user();
    pulse(0,0,1,0,0); exp_fatal(2); do_check(1);
    chk(sup_mode, "R3 mode", sup_mode, 1);
    ret_user();

    // R4 I/O push, R8 svc index
    cur_req = "R4"; pc_in = 'h3A5; pulse(0,0,0,1,0); exp_resume(4); do_check(1);
    chk(sp_out == sp_m, "R4 sp", sp_out, sp_m);
    svc_index = 4'h9; pulse(0,0,0,0,1); svc_index = 4'h2;
    chk(svc_b == 4'h9, "R8 svc_b", svc_b, 9);
    pc_in = 'h3B0; exp_resume(5); do_check(1);
    chk(sp_out == sp_m, "R4 sp svc", sp_out, sp_m);
    ret_user();

    // R5/R6 priority over several pending, one per check
    cur_req = "R5"; pc_in = 'h111;
    pulse(1,1,0,1,1);
    exp_fatal(0); do_check(1);
    cur_req = "R6"; exp_fatal(1); do_check(1);
    cur_req = "R5"; exp_resume(4); do_check(1);
    exp_resume(5); do_check(1);
    cur_req = "R6"; exp_none(); do_check(1);
    chk(sp_out == sp_m, "R6 sp", sp_out, sp_m);
    ret_user();

    // R9 check held during push is ignored
    cur_req = "R9"; pulse(0,0,1,1,0);
    exp_fatal(2); do_check(1);
    pulse(0,0,0,0,1);
    pc_in = 'h222; exp_resume(4); do_check(2);
    exp_resume(5); do_check(1);
    exp_none(); do_check(1);

    // R7 watchdog timing
    cur_req = "R7"; pc_in = 'h333;
    @(negedge clk) begin tmr_load = 1; tmr_value = 8'd5; end
    @(negedge clk) tmr_load = 0;
    repeat (3) @(negedge clk);
    exp_none(); check_req = 1;
    @(negedge clk) check_req = 0;
    @(negedge clk);
    exp_resume(3); check_req = 1;
    @(negedge clk) check_req = 0;
    repeat (3) @(negedge clk);
    repeat (20) @(negedge clk);
    exp_none(); do_check(1);
    @(negedge clk) begin tmr_load = 1; tmr_value = 8'd3; end
    @(negedge clk) begin tmr_load = 1; tmr_value = 8'd0; end
    @(negedge clk) tmr_load = 0;
    repeat (10) @(negedge clk);
    exp_none(); do_check(1);

    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R5 scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule